// File: doc/BRIEF.md
# Serial Port Master FIFO Transfer Engine

This block is the data path of a synchronous serial port master. Software-side writes land in an eight-word transmit queue. Software-side reads take words from an eight-word receive queue. A transfer engine drains the transmit queue into the receive queue. In normal operation it sends each word through a serial shifter on a clock, data-out, data-in and active-low select set of pins. In loopback operation it copies each word internally, with no serial activity.

The word length runs from 1 to 16 bits and is set by a 4-bit size field holding length minus one. Words are trimmed to that length twice: when they enter the transmit queue and when they enter the receive queue. The engine never overruns the receive queue. It holds the next word back until a slot is free, so a read can restart a stalled stream. Clearing the enable stops new words from starting. A word already on the wire still finishes, and the queues keep their contents.

Top module: `ssp_xfer_engine`

## Requirements
- R1: After reset both fill counts are 0, `cs_n` is 1, `sclk` is 0 and `rd_data` is 0.
- R2: A word accepted by `wr_valid` is stored as `wr_data` ANDed with a mask of the low `ctl_dsize`+1 bits.
- R3: A write while `tx_count` is 8 is dropped: the count stays at 8 and the word never reaches the receive queue.
- R4: `rd_data` shows the oldest receive word while `rx_count` is non-zero. With `rx_count` at 0 it shows 0, and a read leaves the count at 0.
- R5: While `ctl_en` is 0 and no word is in flight, no word moves and both counts hold.
- R6: With `ctl_en` and `ctl_loop` both 1, one transmit word per cycle moves to the receive queue, in order, and the serial pins stay idle.
- R7: Each word entering the receive queue is masked with the `ctl_dsize` in force at that moment.
- R8: The engine moves no word while the receive queue holds 8. One read then lets exactly one pending word through.
- R9: In serial mode, `sclk` idles low with a period of 2×`ctl_prescale` clock cycles. `mosi` carries the word most significant bit first. `miso` is sampled on each rising `sclk`.
- R10: `cs_n` is 0 while a serial word is in flight and 1 when the engine is idle. `sclk` is 0 whenever `cs_n` is 1.
- R11: Clearing `ctl_en` during a serial word lets that word complete into the receive queue. No further word starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_en | input | 1 | Engine enable |
| ctl_loop | input | 1 | Internal loopback select |
| ctl_dsize | input | 4 | Word length minus one |
| ctl_prescale | input | 8 | Half-period of `sclk` in clock cycles (0 acts as 1) |
| wr_valid | input | 1 | Push `wr_data` into the transmit queue |
| wr_data | input | 16 | Word to transmit |
| rd_req | input | 1 | Pop the receive queue |
| rd_data | output | 16 | Oldest received word, or 0 when empty |
| tx_count | output | 4 | Transmit queue fill count |
| rx_count | output | 4 | Receive queue fill count |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low select |

## Verification
A write shows in `tx_count` one cycle after its edge.

In loopback, a word moves on the next edge, so `rx_count` rises two cycles after the write. In serial mode, a word starts on the edge after the write and completes 2×prescale×length cycles later.

`rd_data` is valid in the same cycle as the read, because it shows the queue head. The bench sets inputs and samples outputs on falling clock edges. It compares `rd_data` just before the popping edge against a queue of expected words. For counts that depend on the serial pace, it polls until the expected value appears, then checks neighbouring counts and pins at that point.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    localparam int FIFO_DEPTH = 8;
    localparam int WORD_W     = 16;
    localparam int PRESCALE_W = 8;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_LOW,
        ENG_HIGH
    } eng_state_t;

    // Mask of the low nbits bits, saturating at 32.
    function automatic logic [31:0] low_mask(input int unsigned nbits);
        if (nbits >= 32) return '1;
        return (32'd1 << nbits) - 32'd1;
    endfunction
endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CNT_W-1:0] count
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic do_push, do_pop;

    assign do_push = push && (count < CNT_W'(DEPTH));
    assign do_pop  = pop && (count != '0);
    assign head    = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= step(wr_ptr);
            if (do_pop)  rd_ptr <= step(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter
    import ssp_pkg::*;
#(
    parameter int W     = 16,
    parameter int PRE_W = 8,
    localparam int SIZE_W = $clog2(W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [W-1:0]      start_word,
    input  logic [SIZE_W-1:0] dsize,
    input  logic [PRE_W-1:0]  prescale,
    input  logic              miso,
    output logic              busy,
    output logic              ready,
    output logic              last,
    output logic [W-1:0]      rx_word,
    output logic              sclk,
    output logic              mosi
);
    eng_state_t        state;
    logic [PRE_W-1:0]  div;
    logic [PRE_W-1:0]  half_m1;
    logic [SIZE_W-1:0] bits, size_q;
    logic [W-1:0]      tx_sh, rx_sh;
    logic              div_end;

    assign half_m1 = (prescale == '0) ? '0 : prescale - PRE_W'(1);
    assign div_end = (div == half_m1);
    assign busy    = (state != ENG_IDLE);
    assign last    = (state == ENG_HIGH) && div_end && (bits == size_q);
    assign ready   = (state == ENG_IDLE) || last;
    assign rx_word = rx_sh;
    assign mosi    = busy & tx_sh[W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ENG_IDLE;
            div    <= '0;
            bits   <= '0;
            size_q <= '0;
            tx_sh  <= '0;
            rx_sh  <= '0;
            sclk   <= 1'b0;
        end else if (start && ready) begin
            // Left-justify the word so its top bit leaves first.
            tx_sh  <= start_word << (SIZE_W'(W - 1) - dsize);
            size_q <= dsize;
            bits   <= '0;
            div    <= '0;
            sclk   <= 1'b0;
            state  <= ENG_LOW;
        end else begin
            case (state)
                ENG_LOW: begin
                    if (div_end) begin
                        div   <= '0;
                        sclk  <= 1'b1;
                        rx_sh <= {rx_sh[W-2:0], miso};
                        state <= ENG_HIGH;
                    end else begin
                        div <= div + PRE_W'(1);
                    end
                end
                ENG_HIGH: begin
                    if (div_end) begin
                        div  <= '0;
                        sclk <= 1'b0;
                        if (bits == size_q) begin
                            state <= ENG_IDLE;
                        end else begin
                            tx_sh <= tx_sh << 1;
                            bits  <= bits + SIZE_W'(1);
                            state <= ENG_LOW;
                        end
                    end else begin
                        div <= div + PRE_W'(1);
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ssp_xfer_engine.sv
module ssp_xfer_engine
    import ssp_pkg::*;
#(
    parameter int DEPTH  = FIFO_DEPTH,
    parameter int DATA_W = WORD_W,
    parameter int PRE_W  = PRESCALE_W,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int SIZE_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_en,
    input  logic              ctl_loop,
    input  logic [SIZE_W-1:0] ctl_dsize,
    input  logic [PRE_W-1:0]  ctl_prescale,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_req,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  tx_count,
    output logic [CNT_W-1:0]  rx_count,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);
    logic [DATA_W-1:0] size_mask, tx_head, rx_head, sh_rx, rx_push_data;
    logic sh_busy, sh_ready, sh_last;
    logic tx_has, rx_room, spi_start, loop_xfer, tx_pop, rx_push;

    assign size_mask = DATA_W'(low_mask(int'(ctl_dsize) + 1));
    assign tx_has    = (tx_count != '0);

    // A finishing word pushes this edge, so a back-to-back start needs two free slots.
    assign rx_room   = sh_last ? (rx_count < CNT_W'(DEPTH - 1)) : (rx_count < CNT_W'(DEPTH));
    assign spi_start = ctl_en && !ctl_loop && tx_has && rx_room && sh_ready;
    assign loop_xfer = ctl_en && ctl_loop && !sh_busy && tx_has && (rx_count < CNT_W'(DEPTH));

    assign tx_pop       = spi_start || loop_xfer;
    assign rx_push      = sh_last || loop_xfer;
    assign rx_push_data = (sh_last ? sh_rx : tx_head) & size_mask;

    assign rd_data = (rx_count != '0) ? rx_head : '0;
    assign cs_n    = !sh_busy;

    ssp_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_txq (
        .clk(clk), .rst(rst),
        .push(wr_valid), .push_data(wr_data & size_mask),
        .pop(tx_pop), .head(tx_head), .count(tx_count)
    );

    ssp_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_rxq (
        .clk(clk), .rst(rst),
        .push(rx_push), .push_data(rx_push_data),
        .pop(rd_req), .head(rx_head), .count(rx_count)
    );

    ssp_shifter #(.W(DATA_W), .PRE_W(PRE_W)) u_shift (
        .clk(clk), .rst(rst),
        .start(spi_start), .start_word(tx_head), .dsize(ctl_dsize),
        .prescale(ctl_prescale), .miso(miso),
        .busy(sh_busy), .ready(sh_ready), .last(sh_last), .rx_word(sh_rx),
        .sclk(sclk), .mosi(mosi)
    );
endmodule

// File: rtl/ssp_xfer_chk.sv
module ssp_xfer_chk #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              ctl_en,
    input logic              wr_valid,
    input logic              rd_req,
    input logic [DATA_W-1:0] rd_data,
    input logic [CNT_W-1:0]  tx_count,
    input logic [CNT_W-1:0]  rx_count,
    input logic              cs_n,
    input logic              sclk
);
    // R3
    tx_full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_count == CNT_W'(DEPTH) && wr_valid && !ctl_en && cs_n) |=> tx_count == CNT_W'(DEPTH));

    // R4
    empty_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_count == '0) |-> (rd_data == '0));

    // R5
    disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl_en && cs_n && !wr_valid && !rd_req) |=> ($stable(tx_count) && $stable(rx_count)));

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_count == CNT_W'(DEPTH) && !rd_req) |=> rx_count == CNT_W'(DEPTH));

    // R10
    idle_clock_low_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    // R8
    rx_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_count <= CNT_W'(DEPTH)) && (tx_count <= CNT_W'(DEPTH)));
endmodule

bind ssp_xfer_engine ssp_xfer_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .ctl_en(ctl_en), .wr_valid(wr_valid), .rd_req(rd_req),
    .rd_data(rd_data), .tx_count(tx_count), .rx_count(rx_count),
    .cs_n(cs_n), .sclk(sclk)
);

// File: tb/ssp_xfer_engine_tb.sv
module ssp_xfer_engine_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_en = 1'b0, ctl_loop = 1'b0;
    logic [3:0]  ctl_dsize = 4'd7;
    logic [7:0]  ctl_prescale = 8'd1;
    logic        wr_valid = 1'b0, rd_req = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [3:0]  tx_count, rx_count;
    logic        sclk, mosi, miso, cs_n;

    int total = 0, bad = 0, cyc = 0;
    bit finished = 0;
    logic [15:0] exp_q[$];
    logic [15:0] mon_sh = '0;

    always #5 clk = ~clk;
    assign miso = ~mosi;

    ssp_xfer_engine u_dut (
        .clk(clk), .rst(rst), .ctl_en(ctl_en), .ctl_loop(ctl_loop),
        .ctl_dsize(ctl_dsize), .ctl_prescale(ctl_prescale),
        .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req), .rd_data(rd_data),
        .tx_count(tx_count), .rx_count(rx_count),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    // Bits seen on the line at each rising serial clock.
    always @(posedge sclk) mon_sh <= {mon_sh[14:0], mosi};

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: push a word and, when it will arrive, its expected value.
    task automatic wr(input logic [15:0] w, input bit expect_it, input logic [15:0] e);
        wr_valid = 1'b1;
        wr_data  = w;
        if (expect_it) exp_q.push_back(e);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    // Monitor: pop the scoreboard and compare the head shown before the popping edge.
    task automatic rd(input string tag);
        logic [15:0] e;
        e = (exp_q.size() != 0) ? exp_q.pop_front() : 16'h0;
        chk(tag, rd_data, e);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic wait_rx(input int n, input string tag);
        for (int i = 0; i < 3000 && rx_count != n; i++) @(negedge clk);
        chk(tag, rx_count, n);
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        real t1, t2;
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        chk("R1 tx_count", tx_count, 0);
        chk("R1 rx_count", rx_count, 0);
        chk("R1 cs_n", cs_n, 1);
        chk("R1 sclk", sclk, 0);
        chk("R1 rd_data", rd_data, 0);

        // R6 / R2 loopback with 8-bit words
        ctl_en = 1; ctl_loop = 1; ctl_dsize = 4'd7;
        wr(16'h01A5, 1, 16'h00A5);
        wr(16'h003C, 1, 16'h003C);
        wr(16'hFF77, 1, 16'h0077);
        wait_rx(3, "R6 loop count");
        chk("R6 tx drained", tx_count, 0);
        chk("R6 cs_n idle", cs_n, 1);
        for (int i = 0; i < 3; i++) rd("R2 R6 loop data");

        // R2 extreme sizes
        ctl_dsize = 4'd0;
        wr(16'hFFFF, 1, 16'h0001);
        tick(2);
        ctl_dsize = 4'd15;
        wr(16'hBEEF, 1, 16'hBEEF);
        wait_rx(2, "R2 size count");
        rd("R2 one bit");
        rd("R2 sixteen bit");

        // R5 disabled engine holds
        ctl_en = 0;
        wr(16'h0011, 0, 0);
        wr(16'h0022, 0, 0);
        wr(16'h0033, 0, 0);
        tick(10);
        chk("R5 tx held", tx_count, 3);
        chk("R5 rx held", rx_count, 0);

        // R7 receive-side masking uses the current size
        ctl_dsize = 4'd3;
        exp_q.push_back(16'h1); exp_q.push_back(16'h2); exp_q.push_back(16'h3);
        ctl_en = 1;
        wait_rx(3, "R7 count");
        for (int i = 0; i < 3; i++) rd("R7 masked");

        // R3 ninth write dropped
        ctl_en = 0; ctl_dsize = 4'd15;
        for (int i = 0; i < 9; i++) wr(16'h0100 + 16'(i), i < 8, 16'h0100 + 16'(i));
        tick(2);
        chk("R3 tx full", tx_count, 8);
        ctl_en = 1;
        wait_rx(8, "R3 rx filled");
        chk("R3 tx empty", tx_count, 0);

        // R8 stall on full receive queue
        wr(16'h00A1, 1, 16'h00A1);
        wr(16'h00A2, 1, 16'h00A2);
        tick(5);
        chk("R8 tx stalled", tx_count, 2);
        chk("R8 rx full", rx_count, 8);
        rd("R8 first out");
        tick(3);
        chk("R8 one released", tx_count, 1);
        chk("R8 rx refilled", rx_count, 8);
        while (exp_q.size() != 0) begin
            for (int i = 0; i < 50 && rx_count == 0; i++) @(negedge clk);
            rd("R3 R8 order");
            tick(1);
        end
        tick(3);
        chk("R8 rx empty", rx_count, 0);
        chk("R3 nothing extra", tx_count, 0);

        // R4 empty read
        rd("R4 empty data");
        chk("R4 count stays", rx_count, 0);

        // R9 / R10 serial word, 12 bits, prescale 2
        ctl_loop = 0; ctl_dsize = 4'd11; ctl_prescale = 8'd2;
        wr(16'h0ABC, 1, 16'h0543);
        @(posedge sclk); t1 = $realtime;
        @(posedge sclk); t2 = $realtime;
        chk("R9 sclk period", int'((t2 - t1) / 10.0), 4);
        @(negedge clk);
        chk("R10 cs_n active", cs_n, 0);
        wait_rx(1, "R9 word done");
        chk("R9 msb first", mon_sh[11:0], 12'hABC);
        tick(2);
        chk("R10 cs_n idle", cs_n, 1);
        chk("R10 sclk idle", sclk, 0);
        rd("R9 miso capture");

        // R11 disable mid-word
        ctl_prescale = 8'd3; ctl_dsize = 4'd7;
        wr(16'h005A, 1, 16'h00A5);
        wr(16'h00C3, 0, 0);
        tick(6);
        ctl_en = 0;
        tick(70);
        chk("R11 word completed", rx_count, 1);
        chk("R11 next held", tx_count, 1);
        chk("R11 cs_n idle", cs_n, 1);
        rd("R11 data");
        exp_q.push_back(16'h003C);
        ctl_en = 1;
        wait_rx(1, "R11 resumed");
        rd("R11 second data");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule